// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the internal address that a synchronous RAM port uses for each access. Three active-low controls are sampled at every rising clock edge. A load strobe takes the external address and makes it the current address. A count enable steps the current address up by one. A repeat input sends the current address back to the value taken by the most recent load. When none of them is asserted, the address stays as it is.

A separate shadow register holds the most recently loaded address. Only a load writes it, so a burst can be started again any number of times with one repeat command. The controls do not depend on chip enables, byte enables or the read/write direction; those signals never reach this block. The address is registered: an operation sampled at an edge sets the address presented after that edge. A flag shows whether the shadow register has been written by a load since reset, because its contents have no meaning before the first load.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_out` becomes 0, `shadow_valid` becomes 0 and the shadow register is cleared to 0.
- R2: When `rpt_n` is 0 at a rising edge, `addr_out` takes the shadow register value after that edge, whatever `load_n` and `cnt_en_n` are.
- R3: When `rpt_n` is 1 and `load_n` is 0 at a rising edge, `addr_out` and the shadow register both take `ext_addr`, and `shadow_valid` becomes 1.
- R4: When `rpt_n`, `load_n` and `cnt_en_n` are all 1 at a rising edge, `addr_out` keeps its value.
- R5: When `rpt_n` and `load_n` are 1 and `cnt_en_n` is 0 at a rising edge, `addr_out` becomes its previous value plus one.
- R6: Counting from the all-ones address gives address 0.
- R7: Only an accepted load (R3) changes the shadow register. A load strobe together with `rpt_n` at 0 is ignored: neither the shadow register nor `shadow_valid` changes. A later repeat returns the last accepted load address.
- R8: `shadow_valid` stays 0 until the first accepted load and falls only on reset. A repeat before any load gives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External address offered to a load |
| load_n | input | 1 | Load strobe, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| rpt_n | input | 1 | Repeat command, active low |
| addr_out | output | ADDR_W | Address for the current access |
| shadow_valid | output | 1 | High once a load has written the shadow register |

## Verification
A wrong address register is visible at `addr_out` right after the edge where it goes wrong, because the bench compares every cycle. A corrupted shadow register stays hidden until the next repeat. For that reason the random mix issues repeats often, and a directed case checks that a load strobe arriving with a repeat leaves the burst restart point unchanged. Wrap-around and repeat-before-load are driven directly, since random stimulus rarely reaches them.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_STEP   = 2'd1,
        OP_LOAD   = 2'd2,
        OP_REPLAY = 2'd3
    } addr_op_e;

    typedef struct packed {
        addr_op_e op;
        logic     capture;
    } addr_ctrl_t;

    // Fixed priority: replay, then load, then step, then hold.
    function automatic addr_ctrl_t decode_ctrl(input logic load_n,
                                               input logic step_n,
                                               input logic replay_n);
        addr_ctrl_t c;
        c.capture = 1'b0;
        if (!replay_n) begin
            c.op = OP_REPLAY;
        end else if (!load_n) begin
            c.op      = OP_LOAD;
            c.capture = 1'b1;
        end else if (!step_n) begin
            c.op = OP_STEP;
        end else begin
            c.op = OP_HOLD;
        end
        return c;
    endfunction

endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
    import burst_addr_pkg::*;
(
    input  logic       load_n,
    input  logic       cnt_en_n,
    input  logic       rpt_n,
    output addr_ctrl_t ctrl
);

    always_comb begin
        ctrl = decode_ctrl(load_n, cnt_en_n, rpt_n);
    end

    always_comb begin
        // R7: capture only when the load wins priority
        a_r7_capture_is_load: assert (!ctrl.capture || ctrl.op == OP_LOAD);
    end

endmodule

// File: rtl/burst_addr_shadow.sv
module burst_addr_shadow #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic [ADDR_W-1:0] shadow_addr,
    output logic              shadow_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_addr  <= '0;
            shadow_valid <= 1'b0;
        end else if (capture) begin
            shadow_addr  <= cap_addr;
            shadow_valid <= 1'b1;
        end
    end

    a_r7_shadow_kept: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(shadow_addr));

    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        shadow_valid |=> shadow_valid);

endmodule

// File: rtl/burst_addr_cnt.sv
module burst_addr_cnt
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  addr_op_e          op,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] shadow_addr,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        unique case (op)
            OP_REPLAY: addr_d = shadow_addr;
            OP_LOAD:   addr_d = ext_addr;
            OP_STEP:   addr_d = addr_q + ONE;
            default:   addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> $stable(addr_q));

    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && addr_q == {ADDR_W{1'b1}}) |=> addr_q == '0);

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              load_n,
    input  logic              cnt_en_n,
    input  logic              rpt_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic              shadow_valid
);

    addr_ctrl_t        ctrl;
    logic [ADDR_W-1:0] shadow_addr;

    burst_addr_ctrl u_ctrl (
        .load_n   (load_n),
        .cnt_en_n (cnt_en_n),
        .rpt_n    (rpt_n),
        .ctrl     (ctrl)
    );

    burst_addr_shadow #(.ADDR_W(ADDR_W)) u_shadow (
        .clk          (clk),
        .rst          (rst),
        .capture      (ctrl.capture),
        .cap_addr     (ext_addr),
        .shadow_addr  (shadow_addr),
        .shadow_valid (shadow_valid)
    );

    burst_addr_cnt #(.ADDR_W(ADDR_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .op          (ctrl.op),
        .ext_addr    (ext_addr),
        .shadow_addr (shadow_addr),
        .addr_q      (addr_out)
    );

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && !shadow_valid));

    a_r2_replay: assert property (@(posedge clk) disable iff (rst)
        !rpt_n |=> addr_out == $past(shadow_addr));

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (rpt_n && !load_n) |=> (addr_out == $past(ext_addr) && shadow_valid));

    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (rpt_n && load_n && !cnt_en_n) |=> addr_out == ADDR_W'($past(addr_out) + 1'b1));

endmodule

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;

    localparam int AW = 18;
    localparam logic [AW-1:0] AMAX = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          load_n = 1'b1, cnt_en_n = 1'b1, rpt_n = 1'b1;
    logic [AW-1:0] addr_out;
    logic          shadow_valid;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] m_addr = '0, m_shadow = '0;
    logic          m_valid = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .load_n(load_n),
        .cnt_en_n(cnt_en_n), .rpt_n(rpt_n), .addr_out(addr_out),
        .shadow_valid(shadow_valid)
    );

    function automatic string op_tag(logic ld, logic ce, logic rp);
        if (!rp) return "R2";
        if (!ld) return "R3";
        if (!ce) return "R5";
        return "R4";
    endfunction

    task automatic model_step(logic ld, logic ce, logic rp, logic [AW-1:0] ea);
        if (!rp)      m_addr = m_shadow;
        else if (!ld) begin m_addr = ea; m_shadow = ea; m_valid = 1'b1; end
        else if (!ce) m_addr = m_addr + 1'b1;
    endtask

    task automatic check(string tag);
        checks++;
        if (addr_out !== m_addr || shadow_valid !== m_valid) begin
            errors++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     tag, addr_out, shadow_valid, m_addr, m_valid);
        end
    endtask

    task automatic step(logic ld, logic ce, logic rp, logic [AW-1:0] ea, string tag);
        @(negedge clk);
        load_n = ld; cnt_en_n = ce; rpt_n = rp; ext_addr = ea;
        @(posedge clk);
        model_step(ld, ce, rp, ea);
        #1;
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; load_n = 1'b1; cnt_en_n = 1'b1; rpt_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        m_addr = '0; m_shadow = '0; m_valid = 1'b0;
        check("R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));

        do_reset();
        // R8: repeat before any load gives 0, flag stays low
        step(1'b1, 1'b0, 1'b1, '0, "R5");
        step(1'b1, 1'b1, 1'b0, 18'h3_0000, "R8");
        step(1'b0, 1'b0, 1'b0, 18'h1_2345, "R8");
        // R3 then counting and R2 return
        step(1'b0, 1'b1, 1'b1, 18'h0_0100, "R3");
        step(1'b1, 1'b0, 1'b1, '0, "R5");
        step(1'b1, 1'b0, 1'b1, '0, "R5");
        step(1'b1, 1'b1, 1'b1, '0, "R4");
        // R7: load strobe with repeat ignored
        step(1'b0, 1'b0, 1'b0, 18'h2_AAAA, "R7");
        step(1'b1, 1'b0, 1'b1, '0, "R5");
        step(1'b1, 1'b1, 1'b0, '0, "R7");
        // R6: wrap
        step(1'b0, 1'b1, 1'b1, AMAX, "R3");
        step(1'b1, 1'b0, 1'b1, '0, "R6");
        step(1'b1, 1'b0, 1'b1, '0, "R5");
        step(1'b1, 1'b1, 1'b0, '0, "R6");
        // R1: reset after use clears flag
        do_reset();
        step(1'b1, 1'b1, 1'b0, '0, "R8");

        for (int i = 0; i < 3000; i++) begin
            logic ld, ce, rp;
            logic [AW-1:0] ea;
            rp = ($urandom % 100) >= 15;
            ld = ($urandom % 100) >= 25;
            ce = ($urandom % 100) >= 50;
            ea = AW'($urandom);
            if (($urandom % 40) == 0) ea = AMAX - AW'($urandom % 3);
            step(ld, ce, rp, ea, op_tag(ld, ce, rp));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule